// File: doc/BRIEF.md
# Forward-Euler Multi-Scroll Chaos Oscillator Core

This block generates a free-running chaotic trajectory of three state variables, x, y and z, by integrating a jerk-type system with the forward Euler method in signed two's complement fixed point. The z derivative mixes the three states with constant gains and adds a scaled nonlinear term. That term comes from a saturated piecewise-linear function of x, which sits at a negative level below a break point, at a positive level above the mirrored break point, and rises linearly between them. This yields the classic double-scroll attractor.

All arithmetic is registered, one clock per operator. A step controller loads the initial conditions from its input ports in the first clock after reset. It then holds the current state steady while the pipelined datapath computes the next one, and commits that next state a fixed number of clocks later. A one-clock strobe marks each committed triple. With the default parameters the word is 32 bits with 29 fractional bits, the step size is about 0.001, and all four gains are about 0.7.

Top module: `mscroll_euler_core`

## Requirements
- R1: While `rst` is high, and in the sample after any clock edge on which it was high, `x_o`, `y_o`, `z_o` read zero and `step_valid_o` is low.
- R2: On the first clock edge with `rst` low, the state takes the values of `init_x`, `init_y` and `init_z`. Later changes on those ports have no effect until the next reset.
- R3: A new state is committed on every STEP_CLKS-th edge after the load edge (8 by default). `step_valid_o` is high for exactly the one cycle following each commit edge, and is low otherwise.
- R4: The committed x equals x + mul(H, y), where mul(p, q) is the double-width signed product arithmetically shifted right by FRAC bits (rounding toward minus infinity) and truncated to the word width.
- R5: The committed y equals y + mul(H, z).
- R6: The committed z equals z + mul(H, s), with s = −mul(A, x) − mul(B, y) − mul(C, z) + mul(D, f(x)).
- R7: f(x) equals +LEVEL when x ≥ BRK, equals −LEVEL when x ≤ −BRK, and otherwise equals (x·SLOPE) arithmetically shifted right by SLOPE_FRAC bits, where SLOPE carries SLOPE_FRAC fractional bits.
- R8: Every sum and difference wraps modulo 2^W (two's complement), with no saturation.
- R9: Between two commits the outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_x | input | W | Initial x, sampled on the load edge |
| init_y | input | W | Initial y, sampled on the load edge |
| init_z | input | W | Initial z, sampled on the load edge |
| x_o | output | W | Current x state |
| y_o | output | W | Current y state |
| z_o | output | W | Current z state |
| step_valid_o | output | 1 | One-cycle strobe when a new state is committed |

## Verification
The bench drives x exactly onto each break point, one LSB inside each break point, and at zero. A design with an off-by-one compare, or with a linear segment that has the wrong slope, then produces a wrong z after the first step. A start state near the positive limit of the word forces the x sum to overflow; a design that saturates, or that loses the carry into the sign bit, then diverges from the wrapped result. Changing the initial-condition ports in the middle of a run catches a controller that keeps reloading them. A long chaotic run compared every clock exposes a stale pipeline operand or a commit one cycle early, because the trajectory then drifts away within a few steps.

// File: rtl/mscroll_pkg.sv
`timescale 1ns/1ps
package mscroll_pkg;
    // Controller phases: one load cycle after reset, then free running.
    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    // Registered stages on the longest path (state -> next z).
    localparam int CHAIN_DEPTH = 6;
endpackage

// File: rtl/mscroll_fx_mul.sv
`timescale 1ns/1ps
module mscroll_fx_mul #(
    parameter int W    = 32,
    parameter int FRAC = 29
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] p_o
);
    logic signed [2*W-1:0] prod;
    logic signed [W-1:0]   p_d, p_q;

    always_comb begin
        prod = a_i * b_i;
        p_d  = W'(prod >>> FRAC);
    end

    always_ff @(posedge clk) begin
        if (rst) p_q <= '0;
        else     p_q <= p_d;
    end

    assign p_o = p_q;
endmodule

// File: rtl/mscroll_sat_nonlin.sv
`timescale 1ns/1ps
module mscroll_sat_nonlin #(
    parameter int                W          = 32,
    parameter int                SLOPE_FRAC = 24,
    parameter logic signed [W-1:0] LEVEL    = 536870912,
    parameter logic signed [W-1:0] BRK      = 8858370,
    parameter logic signed [W-1:0] SLOPE    = 1016800970
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] x_i,
    output logic signed [W-1:0] f_o
);
    logic signed [2*W-1:0] lin_prod;
    logic signed [W-1:0]   f_d, f_q;

    always_comb begin
        lin_prod = x_i * SLOPE;
        if (x_i >= BRK)
            f_d = LEVEL;
        else if (x_i <= -BRK)
            f_d = -LEVEL;
        else
            f_d = W'(lin_prod >>> SLOPE_FRAC);
    end

    always_ff @(posedge clk) begin
        if (rst) f_q <= '0;
        else     f_q <= f_d;
    end

    assign f_o = f_q;

    // R7: upper saturation region, break point inclusive
    assert_sat_high_R7: assert property (@(posedge clk) disable iff (rst)
        (x_i >= BRK) |=> (f_q == LEVEL));

    // R7: lower saturation region, break point inclusive
    assert_sat_low_R7: assert property (@(posedge clk) disable iff (rst)
        (x_i <= -BRK) |=> (f_q == -LEVEL));
endmodule

// File: rtl/mscroll_datapath.sv
`timescale 1ns/1ps
module mscroll_datapath #(
    parameter int                  W          = 32,
    parameter int                  FRAC       = 29,
    parameter int                  SLOPE_FRAC = 24,
    parameter logic signed [W-1:0] H_STEP     = 536871,
    parameter logic signed [W-1:0] GAIN_A     = 375809638,
    parameter logic signed [W-1:0] GAIN_B     = 375809638,
    parameter logic signed [W-1:0] GAIN_C     = 375809638,
    parameter logic signed [W-1:0] GAIN_D     = 375809638,
    parameter logic signed [W-1:0] LEVEL      = 536870912,
    parameter logic signed [W-1:0] BRK        = 8858370,
    parameter logic signed [W-1:0] SLOPE      = 1016800970
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    input  logic signed [W-1:0] z_i,
    output logic signed [W-1:0] xn_o,
    output logic signed [W-1:0] yn_o,
    output logic signed [W-1:0] zn_o
);
    localparam int NSTATE = 3;
    localparam int NHMUL  = 2;
    localparam logic signed [W-1:0] GAINS [NSTATE] = '{GAIN_A, GAIN_B, GAIN_C};

    logic signed [W-1:0] st     [NSTATE];
    logic signed [W-1:0] gprod  [NSTATE];
    logic signed [W-1:0] hsrc   [NHMUL];
    logic signed [W-1:0] hprod  [NHMUL];
    logic signed [W-1:0] f_q, df_q, hs_q;

    typedef struct packed {
        logic signed [W-1:0] xn;
        logic signed [W-1:0] yn;
        logic signed [W-1:0] s1;
        logic signed [W-1:0] czd;
        logic signed [W-1:0] t;
        logic signed [W-1:0] s1d;
        logic signed [W-1:0] s2;
        logic signed [W-1:0] zn;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    assign st   = '{x_i, y_i, z_i};
    assign hsrc = '{y_i, z_i};

    // Stage 1: gain products on every state
    for (genvar i = 0; i < NSTATE; i++) begin : g_gain
        mscroll_fx_mul #(.W(W), .FRAC(FRAC)) u_mul (
            .clk (clk), .rst (rst),
            .a_i (GAINS[i]), .b_i (st[i]), .p_o (gprod[i])
        );
    end

    // Stage 1: step-size products feeding the x and y updates
    for (genvar i = 0; i < NHMUL; i++) begin : g_hstep
        mscroll_fx_mul #(.W(W), .FRAC(FRAC)) u_mul (
            .clk (clk), .rst (rst),
            .a_i (H_STEP), .b_i (hsrc[i]), .p_o (hprod[i])
        );
    end

    // Stage 1: nonlinear term
    mscroll_sat_nonlin #(
        .W(W), .SLOPE_FRAC(SLOPE_FRAC),
        .LEVEL(LEVEL), .BRK(BRK), .SLOPE(SLOPE)
    ) u_nl (
        .clk (clk), .rst (rst), .x_i (x_i), .f_o (f_q)
    );

    // Stage 2: scaled nonlinear term
    mscroll_fx_mul #(.W(W), .FRAC(FRAC)) u_dmul (
        .clk (clk), .rst (rst),
        .a_i (GAIN_D), .b_i (f_q), .p_o (df_q)
    );

    // Stage 5: step times derivative of z
    mscroll_fx_mul #(.W(W), .FRAC(FRAC)) u_hsmul (
        .clk (clk), .rst (rst),
        .a_i (H_STEP), .b_i (pipe_q.s2), .p_o (hs_q)
    );

    always_comb begin
        pipe_d     = pipe_q;
        pipe_d.xn  = x_i + hprod[0];              // stage 2
        pipe_d.yn  = y_i + hprod[1];              // stage 2
        pipe_d.s1  = -gprod[0] - gprod[1];        // stage 2
        pipe_d.czd = gprod[2];                    // stage 2
        pipe_d.t   = df_q - pipe_q.czd;           // stage 3
        pipe_d.s1d = pipe_q.s1;                   // stage 3
        pipe_d.s2  = pipe_q.s1d + pipe_q.t;       // stage 4
        pipe_d.zn  = z_i + hs_q;                  // stage 6
    end

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= pipe_d;
    end

    assign xn_o = pipe_q.xn;
    assign yn_o = pipe_q.yn;
    assign zn_o = pipe_q.zn;

    // R5: y candidate follows the held state and the registered step product
    assert_y_next_R5: assert property (@(posedge clk) disable iff (rst)
        ($stable(y_i) && $stable(z_i) && $past(!rst)) |=> (yn_o == $past(y_i) + $past(hprod[1])));
endmodule

// File: rtl/mscroll_step_ctrl.sv
`timescale 1ns/1ps
module mscroll_step_ctrl
    import mscroll_pkg::*;
#(
    parameter int W         = 32,
    parameter int STEP_CLKS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] init_x,
    input  logic signed [W-1:0] init_y,
    input  logic signed [W-1:0] init_z,
    input  logic signed [W-1:0] xn_i,
    input  logic signed [W-1:0] yn_i,
    input  logic signed [W-1:0] zn_i,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] y_o,
    output logic signed [W-1:0] z_o,
    output logic                valid_o
);
    localparam int CW = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(STEP_CLKS - 1);

    if (STEP_CLKS <= CHAIN_DEPTH) begin : g_step_too_short
        $error("STEP_CLKS must exceed the datapath chain depth");
    end

    typedef struct packed {
        phase_e              phase;
        logic [CW-1:0]       cnt;
        logic                valid;
        logic signed [W-1:0] x;
        logic signed [W-1:0] y;
        logic signed [W-1:0] z;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.valid = 1'b0;
        case (ctrl_q.phase)
            PH_LOAD: begin
                ctrl_d.x     = init_x;
                ctrl_d.y     = init_y;
                ctrl_d.z     = init_z;
                ctrl_d.cnt   = '0;
                ctrl_d.phase = PH_RUN;
            end
            default: begin
                if (ctrl_q.cnt == LAST) begin
                    ctrl_d.x     = xn_i;
                    ctrl_d.y     = yn_i;
                    ctrl_d.z     = zn_i;
                    ctrl_d.cnt   = '0;
                    ctrl_d.valid = 1'b1;
                end else begin
                    ctrl_d.cnt = ctrl_q.cnt + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign x_o     = ctrl_q.x;
    assign y_o     = ctrl_q.y;
    assign z_o     = ctrl_q.z;
    assign valid_o = ctrl_q.valid;

    // R2: load edge captures the initial-condition ports
    assert_load_init_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.phase == PH_LOAD) |=> (x_o == $past(init_x) && y_o == $past(init_y) && z_o == $past(init_z)));

    // R3: the commit strobe never lasts two cycles
    assert_valid_single_R3: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R9: state holds while no commit is due
    assert_state_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.phase == PH_RUN && ctrl_q.cnt != LAST) |=> ($stable(x_o) && $stable(y_o) && $stable(z_o)));
endmodule

// File: rtl/mscroll_euler_core.sv
`timescale 1ns/1ps
module mscroll_euler_core #(
    parameter int                  W          = 32,
    parameter int                  FRAC       = 29,
    parameter int                  SLOPE_FRAC = 24,
    parameter int                  STEP_CLKS  = 8,
    parameter logic signed [W-1:0] H_STEP     = 536871,
    parameter logic signed [W-1:0] GAIN_A     = 375809638,
    parameter logic signed [W-1:0] GAIN_B     = 375809638,
    parameter logic signed [W-1:0] GAIN_C     = 375809638,
    parameter logic signed [W-1:0] GAIN_D     = 375809638,
    parameter logic signed [W-1:0] LEVEL      = 536870912,
    parameter logic signed [W-1:0] BRK        = 8858370,
    parameter logic signed [W-1:0] SLOPE      = 1016800970
) (
    input  logic                clk,
    input  logic                rst,
    input  logic signed [W-1:0] init_x,
    input  logic signed [W-1:0] init_y,
    input  logic signed [W-1:0] init_z,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] y_o,
    output logic signed [W-1:0] z_o,
    output logic                step_valid_o
);
    logic signed [W-1:0] xn, yn, zn;
    logic signed [W-1:0] xs, ys, zs;

    mscroll_datapath #(
        .W(W), .FRAC(FRAC), .SLOPE_FRAC(SLOPE_FRAC), .H_STEP(H_STEP),
        .GAIN_A(GAIN_A), .GAIN_B(GAIN_B), .GAIN_C(GAIN_C), .GAIN_D(GAIN_D),
        .LEVEL(LEVEL), .BRK(BRK), .SLOPE(SLOPE)
    ) u_dp (
        .clk (clk), .rst (rst),
        .x_i (xs), .y_i (ys), .z_i (zs),
        .xn_o (xn), .yn_o (yn), .zn_o (zn)
    );

    mscroll_step_ctrl #(.W(W), .STEP_CLKS(STEP_CLKS)) u_ctrl (
        .clk (clk), .rst (rst),
        .init_x (init_x), .init_y (init_y), .init_z (init_z),
        .xn_i (xn), .yn_i (yn), .zn_i (zn),
        .x_o (xs), .y_o (ys), .z_o (zs),
        .valid_o (step_valid_o)
    );

    assign x_o = xs;
    assign y_o = ys;
    assign z_o = zs;
endmodule

// File: tb/sim_mscroll_euler_core.sv
`timescale 1ns/1ps
module sim_mscroll_euler_core;
    localparam int FRAC  = 29;
    localparam int SF    = 24;
    localparam int STEP  = 8;
    localparam int H     = 536871;
    localparam int GA    = 375809638;
    localparam int GB    = 375809638;
    localparam int GC    = 375809638;
    localparam int GD    = 375809638;
    localparam int LEVEL = 536870912;
    localparam int BRK   = 8858370;
    localparam int SLOPE = 1016800970;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [31:0] ix = 0, iy = 0, iz = 0;
    logic signed [31:0] x_o, y_o, z_o;
    logic step_valid_o;

    mscroll_euler_core #(
        .W(32), .FRAC(FRAC), .SLOPE_FRAC(SF), .STEP_CLKS(STEP), .H_STEP(H),
        .GAIN_A(GA), .GAIN_B(GB), .GAIN_C(GC), .GAIN_D(GD),
        .LEVEL(LEVEL), .BRK(BRK), .SLOPE(SLOPE)
    ) u0 (
        .clk (clk), .rst (rst),
        .init_x (ix), .init_y (iy), .init_z (iz),
        .x_o (x_o), .y_o (y_o), .z_o (z_o),
        .step_valid_o (step_valid_o)
    );

    always #2 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string xtag  = "R4";
    string ztag  = "R6";

    // reference model state
    int mx = 0, my = 0, mz = 0, mph = 0, mcnt = 0;
    bit mv = 0;
    int prev_x = 0;

    function automatic int fxm(int a, int b);
        longint p;
        p = longint'(a) * longint'(b);
        return int'(p >>> FRAC);
    endfunction

    function automatic int fnl(int x);
        longint p;
        if (x >= BRK)  return LEVEL;
        if (x <= -BRK) return -LEVEL;
        p = longint'(x) * longint'(SLOPE);
        return int'(p >>> SF);
    endfunction

    always @(posedge clk) begin
        int nx, ny, nz, s;
        if (rst) begin
            mx = 0; my = 0; mz = 0; mv = 0; mph = 0; mcnt = 0;
        end else if (mph == 0) begin
            mx = ix; my = iy; mz = iz; mv = 0; mph = 1; mcnt = 0;
        end else if (mcnt == STEP - 1) begin
            nx = mx + fxm(H, my);
            ny = my + fxm(H, mz);
            s  = -fxm(GA, mx) - fxm(GB, my) - fxm(GC, mz) + fxm(GD, fnl(mx));
            nz = mz + fxm(H, s);
            mx = nx; my = ny; mz = nz; mv = 1; mcnt = 0;
        end else begin
            mv = 0; mcnt = mcnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (mph == 0) begin
                chk(x_o === 32'(mx), "R1", "x in reset", x_o, mx);
                chk(y_o === 32'(my), "R1", "y in reset", y_o, my);
                chk(z_o === 32'(mz), "R1", "z in reset", z_o, mz);
                chk(step_valid_o === 1'b0, "R1", "valid in reset", step_valid_o, 0);
            end else begin
                chk(x_o === 32'(mx), xtag, "x", x_o, mx);
                chk(y_o === 32'(my), "R5", "y", y_o, my);
                chk(z_o === 32'(mz), ztag, "z", z_o, mz);
                chk(step_valid_o === mv, "R3", "step valid", step_valid_o, mv);
                if (mcnt != 0)
                    chk(x_o === 32'(prev_x), "R9", "x hold", x_o, prev_x);
            end
            prev_x = x_o;
        end
    end

    task automatic run_case(input int vx, input int vy, input int vz,
                            input string xt, input string zt, input int ncyc);
        @(negedge clk);
        rst = 1'b1;
        ix = vx; iy = vy; iz = vz;
        xtag = xt; ztag = zt;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (ncyc) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R4 R5 R6: long chaotic run from a small x offset
        run_case(53687091, 0, 0, "R4", "R6", 20000);
        // R2: init ports change mid-run and must be ignored
        run_case(-26843546, 107374182, -53687091, "R2", "R6", 40);
        ix = 123456789; iy = -98765432; iz = 55555555;
        repeat (200) @(negedge clk);
        // R7: break points, one LSB inside, and zero
        run_case(BRK,      0, 0, "R4", "R7", 40);
        run_case(BRK - 1,  0, 0, "R4", "R7", 40);
        run_case(-BRK,     0, 0, "R4", "R7", 40);
        run_case(-BRK + 1, 0, 0, "R4", "R7", 40);
        run_case(0, 26843546, -26843546, "R4", "R7", 40);
        // R8: x sum overflows the word and must wrap
        run_case(2147483392, 2140000000, 0, "R8", "R6", 40);
        // R1: reset after running is covered by the next case start
        run_case(-53687091, 0, 0, "R4", "R6", 100);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(4 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule